// File: doc/BRIEF.md
# Configurable Event Counter Bank

This block is a bank of independent event counters for the debug and trace logic of a compute accelerator. Each counter has its own source selector, which picks one of a small set of internal event lines or a constant-high source. It can count every clock cycle in which that line is high, or only the rising edges of the line. With the constant-high source in level mode, a counter becomes a free-running cycle timer on the block clock.

Every counter has its own options: count up or count down, wrap at the terminal value or hold there, and mask its interrupt. Software loads a starting value, starts the counter and stops it again. It can read the count at any time and can rewrite it at any time, which includes clearing it to zero while the counter runs. When a counter reaches its terminal value it sets a sticky flag, unless that flag is masked. The interrupt output is high while any flag is set.

Each counter runs its own four-state controller. IDLE goes to FIRST on a start command. FIRST is the first counting cycle, and edges are ignored in it. FIRST goes to RUN, or goes to SAT when a counter that does not wrap reaches its terminal value. RUN goes to SAT on that same terminal event. A stop command takes FIRST, RUN or SAT back to IDLE.

Top module: `evt_cnt_bank`

## Requirements
- R1: After reset, every counter reads count 0, configuration 0 and not running, and `irq` is low.
- R2: In level mode, a running counter adds one for each clock in which its selected line is high. After a stop command the count holds.
- R3: Source index 0 is constant high, so in level mode the counter adds one on every clock while it runs. Source index k (k ≥ 1) is `evt_in[k-1]`.
- R4: In edge mode, the counter adds one for each clock in which the selected line is high and was low on the previous clock. A rise seen in the first clock after start is never counted.
- R5: When counting up with wrap set, the value all-ones is followed by zero and the counter's flag is set. Counting then continues.
- R6: When counting up without wrap, at all-ones the counter sets its flag, holds the value and stops counting until a stop command.
- R7: In count-down mode the count drops by one for each event. With wrap set, zero is followed by all-ones and the flag is set.
- R8: In count-down mode without wrap, the count holds at zero and the flag is raised once. After software clears the flag it stays clear.
- R9: With the mask bit set, reaching the terminal value never sets the counter's flag.
- R10: A write to the count register loads that value in any state, including while the counter runs. In that cycle the write overrides the counting step.
- R11: Configuration writes take effect only while the counter is stopped. A configuration write to a running counter is ignored.
- R12: The address is {counter index, register[1:0]}. Register 0 is control: write bit0 starts, bit1 stops (stop wins over start), bit2 clears the flag (a new terminal event in the same cycle wins). Reading register 0 gives bit0 running and bit1 flag. Register 1 is configuration: bits [SEL_W-1:0] select the source, bit8 edge mode, bit9 wrap, bit10 count-down, bit11 mask. Register 2 is the count, and register 3 reads zero. `irq` is the OR of all flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_in | input | 2**SEL_W-1 | Event lines; source k reads `evt_in[k-1]` |
| wr_en | input | 1 | Register write strobe |
| addr | input | clog2(NUM_CNT)+2 | Counter index and register select |
| wdata | input | CNT_W | Write data |
| rdata | output | CNT_W | Combinational read data for `addr` |
| irq | output | 1 | High while any unmasked terminal flag is set |

## Verification
A register write lands on the clock edge where `wr_en` is sampled, and the combinational read port shows the new value in the next half cycle. A counting step lands one edge after the event that causes it, and a start command only opens counting from the following edge. The reference model in the bench advances once per edge, using the same inputs the design samples. At every falling edge the bench compares `rdata` at the current address, and `irq`, against the model. This puts every check half a cycle after the edge that produced the result.

// File: rtl/evt_cnt_pkg.sv
package evt_cnt_pkg;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_FIRST = 2'd1,
        S_RUN   = 2'd2,
        S_SAT   = 2'd3
    } cnt_state_e;

    localparam logic [1:0] REG_CTRL = 2'd0;
    localparam logic [1:0] REG_CFG  = 2'd1;
    localparam logic [1:0] REG_CNT  = 2'd2;

    localparam int CMD_START = 0;
    localparam int CMD_STOP  = 1;
    localparam int CMD_CLR   = 2;

    localparam int CFG_EDGE  = 8;
    localparam int CFG_WRAP  = 9;
    localparam int CFG_DOWN  = 10;
    localparam int CFG_MASK  = 11;

endpackage

// File: rtl/evt_cnt_edge.sv
module evt_cnt_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic rise
);
    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= lvl;
    end

    assign rise = lvl & ~prev_q;
endmodule

// File: rtl/evt_cnt_unit.sv
module evt_cnt_unit
    import evt_cnt_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int SEL_W = 3,
    localparam int NUM_SRC = 1 << SEL_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_vec,
    input  logic               cfg_we,
    input  logic               cnt_we,
    input  logic               ctl_we,
    input  logic [CNT_W-1:0]   wdata,
    output logic [CNT_W-1:0]   cnt_o,
    output logic [CNT_W-1:0]   cfg_o,
    output logic               running_o,
    output logic               flag_o
);
    cnt_state_e        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [SEL_W-1:0]  sel_q;
    logic              edge_q, wrap_q, down_q, mask_q, flag_q;
    logic              lvl, rise, active, inc, at_term, term_hit, hold_hit;
    logic              start_cmd, stop_cmd, clr_cmd;

    assign start_cmd = ctl_we & wdata[CMD_START];
    assign stop_cmd  = ctl_we & wdata[CMD_STOP];
    assign clr_cmd   = ctl_we & wdata[CMD_CLR];

    assign lvl = src_vec[sel_q];

    evt_cnt_edge u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .lvl  (lvl),
        .rise (rise)
    );

    assign active   = (state_q == S_FIRST) || (state_q == S_RUN);
    assign inc      = active && (edge_q ? (rise && state_q == S_RUN) : lvl);
    assign at_term  = down_q ? (cnt_q == '0) : (cnt_q == '1);
    assign term_hit = inc && at_term;
    assign hold_hit = term_hit && !wrap_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (start_cmd && !stop_cmd) state_d = S_FIRST;
            S_FIRST: state_d = stop_cmd ? S_IDLE : (hold_hit ? S_SAT : S_RUN);
            S_RUN:   state_d = stop_cmd ? S_IDLE : (hold_hit ? S_SAT : S_RUN);
            S_SAT:   state_d = stop_cmd ? S_IDLE : S_SAT;
            default: state_d = S_IDLE;
        endcase
    end

    // count datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cnt_we) begin
            cnt_q <= wdata;
        end else if (inc) begin
            if (at_term) begin
                if (wrap_q) cnt_q <= down_q ? '1 : '0;
            end else begin
                cnt_q <= down_q ? cnt_q - 1'b1 : cnt_q + 1'b1;
            end
        end
    end

    // configuration, accepted only while stopped
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q  <= '0;
            edge_q <= 1'b0;
            wrap_q <= 1'b0;
            down_q <= 1'b0;
            mask_q <= 1'b0;
        end else if (cfg_we && state_q == S_IDLE) begin
            sel_q  <= wdata[SEL_W-1:0];
            edge_q <= wdata[CFG_EDGE];
            wrap_q <= wdata[CFG_WRAP];
            down_q <= wdata[CFG_DOWN];
            mask_q <= wdata[CFG_MASK];
        end
    end

    // sticky terminal flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  flag_q <= 1'b0;
        else if (term_hit && !mask_q) flag_q <= 1'b1;
        else if (clr_cmd)            flag_q <= 1'b0;
    end

    // outputs
    always_comb begin
        cfg_o              = '0;
        cfg_o[SEL_W-1:0]   = sel_q;
        cfg_o[CFG_EDGE]    = edge_q;
        cfg_o[CFG_WRAP]    = wrap_q;
        cfg_o[CFG_DOWN]    = down_q;
        cfg_o[CFG_MASK]    = mask_q;
        cnt_o              = cnt_q;
        running_o          = (state_q != S_IDLE);
        flag_o             = flag_q;
    end

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && !cnt_we) |=> $stable(cnt_q));

    // R4
    first_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_FIRST && edge_q && !cnt_we) |=> $stable(cnt_q));

    // R6
    sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_SAT && !cnt_we) |=> $stable(cnt_q));

    // R8
    sat_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_SAT && !stop_cmd) |=> (state_q == S_SAT));

    // R9
    mask_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q && !flag_q) |=> !flag_q);

    // R11
    cfg_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_IDLE) |=> $stable(cfg_o));
endmodule

// File: rtl/evt_cnt_bank.sv
module evt_cnt_bank
    import evt_cnt_pkg::*;
#(
    parameter int NUM_CNT = 16,
    parameter int CNT_W   = 32,
    parameter int SEL_W   = 3,
    localparam int IDX_W  = $clog2(NUM_CNT),
    localparam int ADDR_W = IDX_W + 2,
    localparam int NUM_SRC = 1 << SEL_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-2:0] evt_in,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [CNT_W-1:0]   wdata,
    output logic [CNT_W-1:0]   rdata,
    output logic               irq
);
    logic [NUM_SRC-1:0] src_vec;
    logic [IDX_W-1:0]   addr_idx;
    logic [1:0]         addr_reg;
    logic [CNT_W-1:0]   cnt_arr [NUM_CNT];
    logic [CNT_W-1:0]   cfg_arr [NUM_CNT];
    logic [NUM_CNT-1:0] run_vec;
    logic [NUM_CNT-1:0] flag_vec;

    assign src_vec  = {evt_in, 1'b1};
    assign addr_idx = addr[ADDR_W-1:2];
    assign addr_reg = addr[1:0];

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
        logic hit;
        assign hit = wr_en && (addr_idx == IDX_W'(g));

        evt_cnt_unit #(
            .CNT_W(CNT_W),
            .SEL_W(SEL_W)
        ) u_unit (
            .clk      (clk),
            .rst_n    (rst_n),
            .src_vec  (src_vec),
            .cfg_we   (hit && addr_reg == REG_CFG),
            .cnt_we   (hit && addr_reg == REG_CNT),
            .ctl_we   (hit && addr_reg == REG_CTRL),
            .wdata    (wdata),
            .cnt_o    (cnt_arr[g]),
            .cfg_o    (cfg_arr[g]),
            .running_o(run_vec[g]),
            .flag_o   (flag_vec[g])
        );
    end

    always_comb begin
        rdata = '0;
        unique case (addr_reg)
            REG_CTRL: begin
                rdata[0] = run_vec[addr_idx];
                rdata[1] = flag_vec[addr_idx];
            end
            REG_CFG: rdata = cfg_arr[addr_idx];
            REG_CNT: rdata = cnt_arr[addr_idx];
            default: rdata = '0;
        endcase
    end

    assign irq = |flag_vec;

    // R12
    irq_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_vec == '0) |-> !irq);
endmodule

// File: tb/evt_cnt_bank_test.sv
module evt_cnt_bank_test;
    localparam int N = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  evt_in = '0;
    logic        wr_en = 1'b0;
    logic [5:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    evt_cnt_bank uut (
        .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    always #4 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit ev2 = 1'b0;
    string cur_req = "R1";
    logic [5:0] watch = '0;

    logic [31:0] m_cnt  [N];
    logic [31:0] m_cfg  [N];
    int          m_st   [N];
    bit          m_flag [N];
    bit          m_prev [N];

    function automatic bit src_val(int i);
        int s = int'(m_cfg[i][2:0]);
        return (s == 0) ? 1'b1 : evt_in[s-1];
    endfunction

    function automatic logic [31:0] model_read(logic [5:0] a);
        int i = int'(a[5:2]);
        case (a[1:0])
            2'd0: return {30'b0, m_flag[i], (m_st[i] != 0)};
            2'd1: return m_cfg[i];
            2'd2: return m_cnt[i];
            default: return 32'h0;
        endcase
    endfunction

    task automatic model_step();
        for (int i = 0; i < N; i++) begin
            bit hit = wr_en && (int'(addr[5:2]) == i);
            bit sv = src_val(i);
            bit ed = sv && !m_prev[i];
            bit edm = m_cfg[i][8], wr = m_cfg[i][9], dn = m_cfg[i][10], mk = m_cfg[i][11];
            bit inc = 0, setf = 0;
            int ns = m_st[i];
            logic [31:0] nc = m_cnt[i];
            bit nf = m_flag[i];
            logic [31:0] ncfg = m_cfg[i];
            if (m_st[i] == 1 || m_st[i] == 2) begin
                inc = edm ? (m_st[i] == 2 && ed) : sv;
                if (inc) begin
                    if ((!dn && m_cnt[i] == 32'hFFFF_FFFF) || (dn && m_cnt[i] == 0)) begin
                        setf = 1;
                        if (wr) nc = dn ? 32'hFFFF_FFFF : 32'h0;
                        else ns = 3;
                    end else begin
                        nc = dn ? m_cnt[i] - 1 : m_cnt[i] + 1;
                    end
                end
                if (ns == 1) ns = 2;
            end
            if (hit && addr[1:0] == 2'd2) nc = wdata;
            if (hit && addr[1:0] == 2'd0) begin
                if (wdata[2]) nf = 0;
                if (wdata[0] && m_st[i] == 0) ns = 1;
                if (wdata[1]) ns = 0;
            end
            if (setf && !mk) nf = 1;
            if (hit && addr[1:0] == 2'd1 && m_st[i] == 0) ncfg = wdata & 32'h0000_0F07;
            m_prev[i] = sv;
            m_cnt[i]  = nc;
            m_st[i]   = ns;
            m_flag[i] = nf;
            m_cfg[i]  = ncfg;
        end
    endtask

    task automatic compare();
        logic [31:0] exp_r = model_read(addr);
        bit exp_i = 0;
        for (int i = 0; i < N; i++) exp_i |= m_flag[i];
        checks++;
        if (rdata !== exp_r) begin
            errors++;
            $display("FAIL %s rdata addr=%h actual=%h expected=%h", cur_req, addr, rdata, exp_r);
        end
        checks++;
        if (irq !== exp_i) begin
            errors++;
            $display("FAIL %s irq actual=%b expected=%b", cur_req, irq, exp_i);
        end
    endtask

    task automatic tick();
        evt_in    = '0;
        evt_in[0] = cyc[0];
        evt_in[1] = (cyc % 3 == 0);
        evt_in[2] = ev2;
        model_step();
        @(negedge clk);
        cyc++;
        compare();
    endtask

    task automatic wr(int idx, int r, logic [31:0] d);
        wr_en = 1'b1;
        addr  = {idx[3:0], r[1:0]};
        wdata = d;
        tick();
        wr_en = 1'b0;
        addr  = watch;
    endtask

    task automatic idle(int n);
        addr = watch;
        for (int k = 0; k < n; k++) tick();
    endtask

    task automatic rd(int idx, int r);
        addr = {idx[3:0], r[1:0]};
        tick();
        addr = watch;
    endtask

    initial begin
        for (int i = 0; i < N; i++) begin
            m_cnt[i] = 0; m_cfg[i] = 0; m_st[i] = 0; m_flag[i] = 0; m_prev[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state of all registers
        cur_req = "R1";
        for (int i = 0; i < N; i++) begin
            rd(i, 0); rd(i, 1); rd(i, 2); rd(i, 3);
        end

        // R3: constant-high source as a cycle timer
        cur_req = "R3"; watch = {4'd0, 2'd2};
        wr(0, 0, 32'h1);
        idle(10);
        // R2: count holds after stop
        cur_req = "R2";
        wr(0, 0, 32'h2);
        idle(3);

        // R2: level mode on an event line
        watch = {4'd1, 2'd2};
        wr(1, 1, 32'h2);
        wr(1, 0, 32'h1);
        idle(12);
        wr(1, 0, 32'h2);
        idle(2);

        // R4: edge mode on a toggling line
        cur_req = "R4"; watch = {4'd2, 2'd2};
        wr(2, 1, 32'h101);
        wr(2, 0, 32'h1);
        idle(10);
        wr(2, 0, 32'h2);
        rd(2, 2);

        // R4: rise seen in the first cycle is dropped, a later rise counts
        watch = {4'd3, 2'd2};
        wr(3, 1, 32'h103);
        ev2 = 1'b0;
        wr(3, 0, 32'h1);
        ev2 = 1'b1;
        idle(3);
        ev2 = 1'b0;
        idle(2);
        ev2 = 1'b1;
        idle(2);
        wr(3, 0, 32'h2);

        // R5: up count with wrap
        cur_req = "R5"; watch = {4'd4, 2'd2};
        wr(4, 1, 32'h200);
        wr(4, 2, 32'hFFFF_FFFD);
        wr(4, 0, 32'h1);
        idle(5);
        rd(4, 0);
        wr(4, 0, 32'h6);
        cur_req = "R12";
        rd(4, 0);

        // R6: up count saturates
        cur_req = "R6"; watch = {4'd5, 2'd2};
        wr(5, 2, 32'hFFFF_FFFE);
        wr(5, 0, 32'h1);
        idle(6);
        rd(5, 0);
        wr(5, 0, 32'h6);

        // R7: down count with wrap
        cur_req = "R7"; watch = {4'd6, 2'd2};
        wr(6, 1, 32'h600);
        wr(6, 2, 32'h2);
        wr(6, 0, 32'h1);
        idle(5);
        wr(6, 0, 32'h6);

        // R8: down count holds at zero, flag raised once
        cur_req = "R8"; watch = {4'd7, 2'd2};
        wr(7, 1, 32'h400);
        wr(7, 2, 32'h3);
        wr(7, 0, 32'h1);
        idle(7);
        rd(7, 0);
        wr(7, 0, 32'h4);
        idle(3);
        rd(7, 0);
        wr(7, 0, 32'h2);

        // R9: masked counter never flags
        cur_req = "R9"; watch = {4'd8, 2'd2};
        wr(8, 1, 32'hA00);
        wr(8, 2, 32'hFFFF_FFFE);
        wr(8, 0, 32'h1);
        idle(5);
        rd(8, 0);
        wr(8, 0, 32'h2);

        // R10: count writes while running
        cur_req = "R10"; watch = {4'd0, 2'd2};
        wr(0, 0, 32'h1);
        idle(3);
        wr(0, 2, 32'h0);
        idle(2);
        wr(0, 2, 32'd100);
        idle(2);

        // R11: configuration write ignored while running
        cur_req = "R11";
        wr(0, 1, 32'h0000_0101);
        rd(0, 1);
        idle(2);
        wr(0, 0, 32'h2);
        wr(0, 1, 32'h0000_0101);
        rd(0, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule